// File: doc/BRIEF.md
# Smart Card Character Receiver with Selectable Oversampling

This block receives character frames from a smart card line that idles high. It is clocked by a basic clock running at a fixed multiple N of the bit rate. A two-bit select chooses N from four ratios, and one of them (372) is not a power of two. The serial line first passes through a two-flop synchroniser. A high-to-low transition of the synchronised line, seen while the receiver is idle and enabled, starts a frame and restarts a per-bit phase counter from zero. The counter runs from 0 to N-1 and then wraps, so every following bit gets the same bit window.

Each bit is sampled once, on the (N/2)-th basic clock of its window, which is phase count N/2-1. The frame is a start bit, eight data bits received least significant bit first, and an even parity bit. After the parity bit, one more mid-bit sample of the line checks that the line has returned high. At that point the receiver issues a one-cycle valid pulse with the byte, a parity error flag and a framing error flag, and goes back to idle.

Top module: `sc_rx_sampler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rx_valid, rx_data, parity_err and frame_err are all zero.
- R2: ratio_sel encodes N as 2'b00=32, 2'b01=64, 2'b10=372, 2'b11=256. rx_valid rises exactly 10*N + N/2 + 3 clock edges after the first edge that sees the line low at the start of a frame.
- R3: The eight data bits that follow the start bit are placed into rx_data least significant bit first: the first data bit lands in bit 0.
- R4: parity_err is 1 when the eight data bits plus the parity bit hold an odd number of ones, and 0 otherwise.
- R5: frame_err is 1 when the line is low at the mid-bit sample one bit after the parity bit, and 0 when it is high.
- R6: rx_valid is high for exactly one cycle per character. rx_data, parity_err and frame_err change only in the cycle rx_valid is high and hold their values between pulses.
- R7: A falling edge whose start bit reads high at its mid-bit sample is dropped: no character is produced, and the next good frame is received correctly.
- R8: While rx_en is low, a falling edge starts no frame and produces no rx_valid.
- R9: ratio_sel is used only while the receiver is idle. A change during a frame has no effect on that frame's timing or data.
- R10: While a frame is in progress, the phase counter stays within 0..N-1 and goes from N-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Basic clock, N times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | 2 | Oversampling ratio select (see R2) |
| rx_en | input | 1 | Allows a falling edge to start a frame |
| rx_line | input | 1 | Serial line from the card, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a character is complete |
| parity_err | output | 1 | Even parity mismatch for the last character |
| frame_err | output | 1 | Line low at the check point after parity |

## Verification
The bench measures the exact cycle of rx_valid for every ratio, including 372. A design that derives the mid-bit point or the wrap point by shifting, or that miscounts the synchroniser delay, lands on the wrong cycle or samples the wrong bit. A select change in the middle of a frame catches a design that reads ratio_sel live: its timing would jump to the new ratio. Short low glitches and edges while disabled catch a design that produces spurious characters or stays stuck busy. Odd-parity and low-stop frames catch an inverted parity sense or a missing framing check, and back-to-back frames catch a receiver that is not back in idle before the next start edge.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  // Ratio chosen by the two-bit select
  function automatic int unsigned pick_ratio(input logic [1:0] sel,
                                             input int unsigned r0, input int unsigned r1,
                                             input int unsigned r2, input int unsigned r3);
    case (sel)
      2'b00:   return r0;
      2'b01:   return r1;
      2'b10:   return r2;
      default: return r3;
    endcase
  endfunction

  // Phase count at which a bit is sampled: the (n/2)-th clock of the window
  function automatic int unsigned sample_at(input int unsigned n);
    return n / 2 - 1;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line_o,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], din};
  end

  assign line_o = pipe_q[STAGES-1];
  assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/sc_rx_phase.sv
module sc_rx_phase #(
  parameter int PHW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           run,
  input  logic [PHW-1:0] limit,
  output logic [PHW-1:0] phase_o,
  output logic           sample_o
);
  logic [PHW-1:0] cnt_q;
  logic [PHW-1:0] last_cnt;
  logic [PHW-1:0] mid_cnt;

  assign last_cnt = limit - 1'b1;
  assign mid_cnt  = PHW'(sc_rx_pkg::sample_at(32'(limit)));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (run)      cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + 1'b1;
  end

  assign phase_o  = cnt_q;
  assign sample_o = run && (cnt_q == mid_cnt);
endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame #(
  parameter int DATA_W = 8,
  parameter int IDXW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sample,
  input  logic              line,
  output logic              busy_o,
  output logic [IDXW-1:0]   bit_idx_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam logic [IDXW-1:0] LAST_DATA = IDXW'(DATA_W);
  localparam logic [IDXW-1:0] PAR_IDX   = IDXW'(DATA_W + 1);

  logic              busy_q;
  logic [IDXW-1:0]   idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q && sample) begin
        if (idx_q == '0) begin
          // start bit must still be low at mid-bit, otherwise a glitch
          if (line) busy_q <= 1'b0;
          else      idx_q  <= idx_q + 1'b1;
        end else if (idx_q <= LAST_DATA) begin
          shift_q <= {line, shift_q[DATA_W-1:1]};
          idx_q   <= idx_q + 1'b1;
        end else if (idx_q == PAR_IDX) begin
          par_q <= line;
          idx_q <= idx_q + 1'b1;
        end else begin
          valid_o <= 1'b1;
          data_o  <= shift_q;
          perr_o  <= (^shift_q) ^ par_q;
          ferr_o  <= ~line;
          busy_q  <= 1'b0;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign bit_idx_o = idx_q;
endmodule

// File: rtl/sc_rx_sampler.sv
module sc_rx_sampler #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RATIO_0     = 32,
  parameter int RATIO_1     = 64,
  parameter int RATIO_2     = 372,
  parameter int RATIO_3     = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ratio_sel,
  input  logic              rx_en,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              parity_err,
  output logic              frame_err
);
  localparam int PHW  = $clog2(sc_rx_pkg::max4(RATIO_0, RATIO_1, RATIO_2, RATIO_3));
  localparam int IDXW = $clog2(DATA_W + 3);

  // named internal events, observed by the checker
  logic           line_s;
  logic           fall_s;
  logic           busy;
  logic           start_ev;
  logic           samp_ev;
  logic [PHW-1:0] phase;
  logic [PHW-1:0] n_lat;
  logic [IDXW-1:0] bit_idx;

  sc_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .line_o(line_s), .fall_o(fall_s)
  );

  assign start_ev = !busy && rx_en && fall_s;

  // ratio is followed while idle and frozen for the whole frame
  always_ff @(posedge clk) begin
    if (!rst_n)     n_lat <= PHW'(RATIO_0);
    else if (!busy) n_lat <= PHW'(sc_rx_pkg::pick_ratio(ratio_sel, RATIO_0, RATIO_1,
                                                        RATIO_2, RATIO_3));
  end

  sc_rx_phase #(.PHW(PHW)) phase_i (
    .clk(clk), .rst_n(rst_n), .restart(start_ev), .run(busy), .limit(n_lat),
    .phase_o(phase), .sample_o(samp_ev)
  );

  sc_rx_frame #(.DATA_W(DATA_W), .IDXW(IDXW)) frame_i (
    .clk(clk), .rst_n(rst_n), .start(start_ev), .sample(samp_ev), .line(line_s),
    .busy_o(busy), .bit_idx_o(bit_idx), .data_o(rx_data), .valid_o(rx_valid),
    .perr_o(parity_err), .ferr_o(frame_err)
  );
endmodule

// File: rtl/sc_rx_sampler_chk.sv
module sc_rx_sampler_chk #(
  parameter int DATA_W = 8,
  parameter int PHW    = 9,
  parameter int IDXW   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              parity_err,
  input logic              frame_err,
  input logic              busy,
  input logic              samp_ev,
  input logic              line_s,
  input logic [PHW-1:0]    phase,
  input logic [PHW-1:0]    n_lat,
  input logic [IDXW-1:0]   bit_idx
);
  // R6: single-cycle valid
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: outputs hold between pulses
  a_r6_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(parity_err) && $stable(frame_err)));

  // R10: phase counter range
  a_r10_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (phase < n_lat));

  // R10: wrap at N-1
  a_r10_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == n_lat - 1'b1) |=> (phase == '0));

  // R9: ratio frozen while a frame runs
  a_r9_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(n_lat));

  // R8: no frame starts while disabled
  a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_en) |=> !busy);

  // R7: high start sample abandons the frame without a character
  a_r7_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && samp_ev && bit_idx == '0 && line_s) |=> (!busy && !rx_valid));
endmodule

bind sc_rx_sampler sc_rx_sampler_chk #(.DATA_W(DATA_W), .PHW(PHW), .IDXW(IDXW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid), .rx_data(rx_data),
  .parity_err(parity_err), .frame_err(frame_err), .busy(busy), .samp_ev(samp_ev),
  .line_s(line_s), .phase(phase), .n_lat(n_lat), .bit_idx(bit_idx)
);

// File: tb/sc_rx_sampler_tb_top.sv
`timescale 1ns/1ps
module sc_rx_sampler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic       rx_en = 1'b0;
  logic       rx_line = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       parity_err;
  logic       frame_err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int vcount = 0;
  int got_cyc = 0;
  logic [7:0] got_data = '0;
  logic got_perr = 1'b0, got_ferr = 1'b0;
  int start_cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_rx_sampler dut_i (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .rx_en(rx_en), .rx_line(rx_line),
    .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      vcount   = vcount + 1;
      got_cyc  = cyc;
      got_data = rx_data;
      got_perr = parity_err;
      got_ferr = frame_err;
    end
  end

  function automatic int ratio_n(input logic [1:0] s);
    case (s)
      2'b00: return 32;
      2'b01: return 64;
      2'b10: return 372;
      default: return 256;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_bits(input int n, input int bits);
    rx_line = 1'b1;
    repeat (n * bits) @(negedge clk);
  endtask

  // Drive one frame at ratio of sel; select switches to alt_sel during data bit 4
  task automatic send_frame(input logic [1:0] sel, input logic [1:0] alt_sel,
                            input logic [7:0] d, input logic par, input logic stop);
    int n;
    logic [10:0] bits;
    n = ratio_n(sel);
    bits = {stop, par, d, 1'b0};
    ratio_sel = sel;
    @(negedge clk);
    start_cyc = cyc;
    for (int b = 0; b < 11; b++) begin
      rx_line = bits[b];
      if (b == 5) ratio_sel = alt_sel;
      repeat (n) @(negedge clk);
    end
    ratio_sel = sel;
  endtask

  task automatic expect_char(input logic [1:0] sel, input int v0, input logic [7:0] d,
                             input logic pe, input logic fe, input string tag);
    int n;
    n = ratio_n(sel);
    check(vcount == v0 + 1, {tag, " valid count"}, vcount, v0 + 1);
    check(got_cyc == start_cyc + 3 + 10 * n + n / 2, {tag, " R2 latency"},
          got_cyc - start_cyc, 3 + 10 * n + n / 2);
    check(got_data == d, {tag, " R3 data"}, got_data, d);
    check(got_perr == pe, {tag, " R4 parity_err"}, got_perr, pe);
    check(got_ferr == fe, {tag, " R5 frame_err"}, got_ferr, fe);
  endtask

  task automatic t_reset;
    check(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);
    check(rx_data == 8'h00, "R1 reset rx_data", rx_data, 0);
    check(parity_err == 1'b0, "R1 reset parity_err", parity_err, 0);
    check(frame_err == 1'b0, "R1 reset frame_err", frame_err, 0);
  endtask

  task automatic t_all_ratios;
    logic [7:0] pat [4];
    pat[0] = 8'hA5; pat[1] = 8'h01; pat[2] = 8'h3C; pat[3] = 8'h80;
    for (int s = 0; s < 4; s++) begin
      int v0;
      v0 = vcount;
      send_frame(2'(s), 2'(s), pat[s], ^pat[s], 1'b1);
      expect_char(2'(s), v0, pat[s], 1'b0, 1'b0, "R2 ratio");
      idle_bits(ratio_n(2'(s)), 1);
    end
  endtask

  task automatic t_parity;
    int v0;
    v0 = vcount;
    send_frame(2'b00, 2'b00, 8'h6E, ~(^8'h6E), 1'b1);
    expect_char(2'b00, v0, 8'h6E, 1'b1, 1'b0, "R4 odd");
    idle_bits(32, 1);
  endtask

  task automatic t_framing;
    int v0;
    v0 = vcount;
    send_frame(2'b01, 2'b01, 8'hC3, ^8'hC3, 1'b0);
    expect_char(2'b01, v0, 8'hC3, 1'b0, 1'b1, "R5 low stop");
    idle_bits(64, 2);
    // R6: values held after the pulse
    check(rx_data == 8'hC3 && frame_err == 1'b1, "R6 hold", rx_data, 8'hC3);
  endtask

  task automatic t_glitch;
    int v0;
    v0 = vcount;
    ratio_sel = 2'b00;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    idle_bits(32, 12);
    check(vcount == v0, "R7 glitch no char", vcount, v0);
    send_frame(2'b00, 2'b00, 8'h5A, ^8'h5A, 1'b1);
    expect_char(2'b00, v0, 8'h5A, 1'b0, 1'b0, "R7 after glitch");
    idle_bits(32, 1);
  endtask

  task automatic t_disabled;
    int v0;
    v0 = vcount;
    rx_en = 1'b0;
    send_frame(2'b00, 2'b00, 8'hFF, 1'b0, 1'b1);
    idle_bits(32, 2);
    check(vcount == v0, "R8 disabled no valid", vcount, v0);
    check(rx_data == 8'h5A, "R8 disabled data kept", rx_data, 8'h5A);
    rx_en = 1'b1;
    idle_bits(32, 1);
  endtask

  task automatic t_sel_change;
    int v0;
    v0 = vcount;
    send_frame(2'b00, 2'b10, 8'h96, ^8'h96, 1'b1);
    expect_char(2'b00, v0, 8'h96, 1'b0, 1'b0, "R9 sel change");
    idle_bits(32, 1);
  endtask

  task automatic t_back_to_back;
    int v0;
    v0 = vcount;
    send_frame(2'b11, 2'b11, 8'h12, ^8'h12, 1'b1);
    expect_char(2'b11, v0, 8'h12, 1'b0, 1'b0, "R10 b2b first");
    send_frame(2'b11, 2'b11, 8'hED, ^8'hED, 1'b1);
    expect_char(2'b11, v0 + 1, 8'hED, 1'b0, 1'b0, "R10 b2b second");
    idle_bits(256, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    idle_bits(32, 1);
    t_all_ratios();
    t_parity();
    t_framing();
    t_glitch();
    t_disabled();
    t_sel_change();
    t_back_to_back();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule